// File: doc/BRIEF.md
# Indirect Memory XOR-Immediate Execution Unit

This unit carries out the "exclusive-OR a 4-bit constant into a memory nibble" instructions of a 4-bit microcontroller core. It takes a 13-bit instruction word with a valid strobe and checks it against the opcode pattern. It reads one nibble from a synchronous nibble-wide data memory, XORs it with the constant held in the low bits of the word, and writes the result back to the same location. Each instruction spends one cycle reading and one cycle writing.

The location comes from one of two 16-bit index registers, which live in this unit. The post-increment forms step the selected register by one after the write, and that step leaves the flags alone. A one-shot extension prefix carries an 8-bit value. On the next instruction, if that instruction is a non-incrementing form, the value replaces the index register: the X form addresses page 00h and the Y form addresses page FFh. The prefix is used up by that instruction whether or not the instruction applied it. The zero flag follows the result nibble and the carry flag is kept. Side ports let the surrounding core load the index registers and the flags.

Top module: `xim_unit`

## Requirements
- R1: A word is executed only when bits [12:6] equal 1101110b. Any other word causes no memory access, leaves X, Y and the flags unchanged, and leaves a pending prefix pending.
- R2: In the cycle after an instruction is accepted, the unit asserts mem_rd_en and instr_ready is low. In the cycle after that, it asserts mem_wr_en and done together, for one cycle only.
- R3: The value written is the nibble read XOR the immediate in bits [3:0]. It goes to the address that was read.
- R4: Bit 5 selects the index register (0 = X, 1 = Y). When bit 4 is 1, the selected register becomes address+1 at the end of the write cycle, wrapping from FFFFh to 0000h. When bit 4 is 0, both registers are left unchanged.
- R5: At the end of the write cycle, flag_z becomes 1 if the result is 0000b and 0 otherwise. flag_c keeps its value.
- R6: If a prefix is pending when a non-incrementing form is accepted, the address is {00h, prefix value} for X and {FFh, prefix value} for Y, instead of the index register.
- R7: A post-increment form always addresses through its index register, even when a prefix is pending. Any executed instruction clears the pending prefix at the end of its write cycle.
- R8: instr_ready is high except in the read cycle. An instruction can therefore be accepted during the write cycle of the previous one, and it sees that instruction's index update and prefix clearing. If a prefix and an instruction arrive in the same accepted cycle, the prefix is taken and the instruction is dropped.
- R9: After reset X, Y, flag_z, flag_c and ext_pending are 0, no memory strobe is active, done is 0 and instr_ready is 1.
- R10: idx_wr_en loads idx_wr_data into Y (idx_wr_sel = 1) or X (idx_wr_sel = 0). flag_wr_en loads flag_c and flag_z. Both loads take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 13 | Instruction word |
| instr_ready | output | 1 | Unit can accept a word or prefix this cycle |
| prefix_valid | input | 1 | Extension prefix present |
| prefix_imm | input | 8 | Prefix value |
| mem_rd_en | output | 1 | Memory read strobe (data next cycle) |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 4 | Write nibble |
| mem_rdata | input | 4 | Read nibble, registered by the memory |
| idx_wr_en | input | 1 | Index register load strobe |
| idx_wr_sel | input | 1 | Index register chosen for load (1 = Y) |
| idx_wr_data | input | 16 | Index register load value |
| idx_x | output | 16 | X index register |
| idx_y | output | 16 | Y index register |
| flag_wr_en | input | 1 | Flag load strobe |
| flag_wr_c | input | 1 | Carry load value |
| flag_wr_z | input | 1 | Zero load value |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| ext_pending | output | 1 | Prefix waiting to be used |
| done | output | 1 | Write cycle of an instruction |

## Verification
A wrong latched address shows up in the write cycle, two cycles after acceptance: mem_addr differs from the location the bench model expects, or from the address of the read cycle just before it. A bad index update or a lost or stale prefix bit does not show at once. It shows on the next instruction that uses that register, as a write to the wrong page or offset, and the index and ext_pending outputs expose it one cycle after done. A wrong zero or carry flag is visible on the flag outputs the cycle after the write, so every scenario compares them right after completion.

// File: rtl/xim_pkg.sv
package xim_pkg;

    localparam int OPC_W = 7;
    localparam logic [OPC_W-1:0] OPC_XOR_IMM = 7'b1101110;

    localparam int DEF_ADDR_W = 16;
    localparam int DEF_EXT_W  = 8;
    localparam int DEF_DATA_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xim_state_e;

endpackage

// File: rtl/xim_decode.sv
module xim_decode
    import xim_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    localparam int INSTR_W = OPC_W + 2 + DATA_W
) (
    input  logic [INSTR_W-1:0] word,
    output logic               hit,
    output logic               sel_y,
    output logic               post_inc,
    output logic [DATA_W-1:0]  imm
);
    localparam int SEL_BIT = DATA_W + 1;
    localparam int INC_BIT = DATA_W;

    always_comb begin
        hit      = (word[INSTR_W-1 -: OPC_W] == OPC_XOR_IMM);
        sel_y    = word[SEL_BIT];
        post_inc = word[INC_BIT];
        imm      = word[DATA_W-1:0];
    end
endmodule

// File: rtl/xim_addr_gen.sv
module xim_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int EXT_W  = 8
) (
    input  logic              ext_on,
    input  logic              post_inc,
    input  logic              sel_y,
    input  logic [EXT_W-1:0]  ext_imm,
    input  logic [ADDR_W-1:0] idx_x,
    input  logic [ADDR_W-1:0] idx_y,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAGE_W = ADDR_W - EXT_W;

    logic [PAGE_W-1:0] page;
    logic              use_ext;

    always_comb begin
        use_ext = ext_on && !post_inc;
        page    = sel_y ? {PAGE_W{1'b1}} : {PAGE_W{1'b0}};
        if (use_ext) begin
            addr = {page, ext_imm};
        end else if (sel_y) begin
            addr = idx_y;
        end else begin
            addr = idx_x;
        end
    end
endmodule

// File: rtl/xim_datapath.sv
module xim_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] rd_nib,
    input  logic [DATA_W-1:0] imm,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wr_nib,
    output logic              zero,
    output logic [ADDR_W-1:0] addr_next
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        wr_nib    = rd_nib ^ imm;
        zero      = (wr_nib == {DATA_W{1'b0}});
        addr_next = addr + ONE;
    end
endmodule

// File: rtl/xim_unit.sv
module xim_unit
    import xim_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int EXT_W  = DEF_EXT_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int INSTR_W = OPC_W + 2 + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    output logic               instr_ready,
    input  logic               prefix_valid,
    input  logic [EXT_W-1:0]   prefix_imm,
    output logic               mem_rd_en,
    output logic               mem_wr_en,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               idx_wr_en,
    input  logic               idx_wr_sel,
    input  logic [ADDR_W-1:0]  idx_wr_data,
    output logic [ADDR_W-1:0]  idx_x,
    output logic [ADDR_W-1:0]  idx_y,
    input  logic               flag_wr_en,
    input  logic               flag_wr_c,
    input  logic               flag_wr_z,
    output logic               flag_c,
    output logic               flag_z,
    output logic               ext_pending,
    output logic               done
);

    typedef struct packed {
        xim_state_e        st;
        logic              sel_y;
        logic              post_inc;
        logic [DATA_W-1:0] imm;
        logic [ADDR_W-1:0] addr;
        logic              ext_on;
        logic [EXT_W-1:0]  ext_imm;
        logic [ADDR_W-1:0] x;
        logic [ADDR_W-1:0] y;
        logic              fz;
        logic              fc;
    } xim_regs_t;

    xim_regs_t r_q, r_d;

    // decoded fields of the incoming word
    logic              dec_hit, dec_sel_y, dec_inc;
    logic [DATA_W-1:0] dec_imm;

    // state after the retiring instruction and side loads, seen by a new accept
    logic [ADDR_W-1:0] nx_x, nx_y;
    logic              nx_ext;
    logic [ADDR_W-1:0] acc_addr;

    // datapath results for the instruction in its write cycle
    logic [DATA_W-1:0] wr_nib;
    logic              res_zero;
    logic [ADDR_W-1:0] addr_inc;

    logic in_read, in_write, accept_ok;

    xim_decode #(.DATA_W(DATA_W)) u_dec (
        .word     (instr_word),
        .hit      (dec_hit),
        .sel_y    (dec_sel_y),
        .post_inc (dec_inc),
        .imm      (dec_imm)
    );

    xim_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .rd_nib    (mem_rdata),
        .imm       (r_q.imm),
        .addr      (r_q.addr),
        .wr_nib    (wr_nib),
        .zero      (res_zero),
        .addr_next (addr_inc)
    );

    xim_addr_gen #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_agen (
        .ext_on   (nx_ext),
        .post_inc (dec_inc),
        .sel_y    (dec_sel_y),
        .ext_imm  (r_q.ext_imm),
        .idx_x    (nx_x),
        .idx_y    (nx_y),
        .addr     (acc_addr)
    );

    always_comb begin
        in_read   = (r_q.st == ST_READ);
        in_write  = (r_q.st == ST_WRITE);
        accept_ok = !in_read;
    end

    // retirement of the write-cycle instruction plus side loads
    always_comb begin
        nx_x   = r_q.x;
        nx_y   = r_q.y;
        nx_ext = r_q.ext_on;
        if (in_write) begin
            nx_ext = 1'b0;
            if (r_q.post_inc) begin
                if (r_q.sel_y) begin
                    nx_y = addr_inc;
                end else begin
                    nx_x = addr_inc;
                end
            end
        end
        if (idx_wr_en) begin
            if (idx_wr_sel) begin
                nx_y = idx_wr_data;
            end else begin
                nx_x = idx_wr_data;
            end
        end
    end

    // next-state of every register
    always_comb begin
        r_d        = r_q;
        r_d.x      = nx_x;
        r_d.y      = nx_y;
        r_d.ext_on = nx_ext;

        case (r_q.st)
            ST_READ:  r_d.st = ST_WRITE;
            ST_WRITE: begin
                r_d.st = ST_IDLE;
                r_d.fz = res_zero;
            end
            default:  r_d.st = ST_IDLE;
        endcase

        if (flag_wr_en) begin
            r_d.fc = flag_wr_c;
            r_d.fz = flag_wr_z;
        end

        if (accept_ok && prefix_valid) begin
            r_d.ext_on  = 1'b1;
            r_d.ext_imm = prefix_imm;
        end else if (accept_ok && instr_valid && dec_hit) begin
            r_d.st       = ST_READ;
            r_d.sel_y    = dec_sel_y;
            r_d.post_inc = dec_inc;
            r_d.imm      = dec_imm;
            r_d.addr     = acc_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, sel_y: 1'b0, post_inc: 1'b0, imm: '0,
                     addr: '0, ext_on: 1'b0, ext_imm: '0, x: '0, y: '0,
                     fz: 1'b0, fc: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        instr_ready = accept_ok;
        mem_rd_en   = in_read;
        mem_wr_en   = in_write;
        mem_addr    = r_q.addr;
        mem_wdata   = wr_nib;
        idx_x       = r_q.x;
        idx_y       = r_q.y;
        flag_c      = r_q.fc;
        flag_z      = r_q.fz;
        ext_pending = r_q.ext_on;
        done        = in_write;
    end

endmodule

// File: rtl/xim_unit_checker.sv
module xim_unit_checker
    import xim_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int EXT_W  = DEF_EXT_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int INSTR_W = OPC_W + 2 + DATA_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr_word,
    input logic               instr_ready,
    input logic               prefix_valid,
    input logic               mem_rd_en,
    input logic               mem_wr_en,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic               idx_wr_en,
    input logic [ADDR_W-1:0]  idx_x,
    input logic [ADDR_W-1:0]  idx_y,
    input logic               flag_wr_en,
    input logic               flag_c,
    input logic               flag_z,
    input logic               ext_pending,
    input logic               done
);

    assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (mem_wr_en && done && !mem_rd_en));

    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    assert_write_same_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && (mem_addr == $past(mem_addr))));

    assert_carry_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr_en |=> $stable(flag_c));

    assert_zero_follows_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !flag_wr_en) |=> (flag_z == ($past(mem_wdata) == '0)));

    assert_prefix_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !prefix_valid) |=> !ext_pending);

    assert_index_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !idx_wr_en) |=> ($stable(idx_x) && $stable(idx_y)));

    assert_bad_word_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && !prefix_valid &&
         (instr_word[INSTR_W-1 -: OPC_W] != OPC_XOR_IMM)) |=> !mem_rd_en);

endmodule

bind xim_unit xim_unit_checker #(
    .ADDR_W(ADDR_W),
    .EXT_W (EXT_W),
    .DATA_W(DATA_W)
) u_xim_chk (.*);

// File: tb/tb_xim_unit.sv
module tb_xim_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [12:0] instr_word = '0;
    logic        instr_ready;
    logic        prefix_valid = 1'b0;
    logic [7:0]  prefix_imm = '0;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_addr;
    logic [3:0]  mem_wdata;
    logic [3:0]  mem_rdata = '0;
    logic        idx_wr_en = 1'b0;
    logic        idx_wr_sel = 1'b0;
    logic [15:0] idx_wr_data = '0;
    logic [15:0] idx_x, idx_y;
    logic        flag_wr_en = 1'b0, flag_wr_c = 1'b0, flag_wr_z = 1'b0;
    logic        flag_c, flag_z, ext_pending, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    xim_unit dut (.*);

    int checks = 0;
    int failures = 0;
    int writes_seen = 0;

    typedef struct packed {
        logic [15:0] a;
        logic [3:0]  w;
    } exp_t;
    exp_t exp_q[$];

    logic [3:0] dmem [int];
    logic [3:0] emem [int];

    function automatic logic [3:0] seed_nib(input logic [15:0] a);
        return a[3:0] ^ a[11:8] ^ 4'h5;
    endfunction

    // bench memory: synchronous read, write on strobe
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : seed_nib(mem_addr);
        if (mem_wr_en) dmem[int'(mem_addr)] = mem_wdata;
    end

    // reference model state
    logic [15:0] mx = '0, my = '0;
    logic        mz = 1'b0, mc = 1'b0, me = 1'b0;
    logic [7:0]  meimm = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [3:0] exp_rd(input logic [15:0] a);
        return emem.exists(int'(a)) ? emem[int'(a)] : seed_nib(a);
    endfunction

    function automatic logic [15:0] model_addr(input logic [12:0] w);
        if (me && !w[4]) return w[5] ? {8'hFF, meimm} : {8'h00, meimm};
        return w[5] ? my : mx;
    endfunction

    task automatic model_exec(input logic [12:0] w);
        logic [15:0] a;
        logic [3:0]  n;
        if (w[12:6] != 7'b1101110) return;
        a = model_addr(w);
        n = exp_rd(a) ^ w[3:0];
        emem[int'(a)] = n;
        exp_q.push_back('{a: a, w: n});
        mz = (n == 4'h0);
        me = 1'b0;
        if (w[4]) begin
            if (w[5]) my = a + 16'd1; else mx = a + 16'd1;
        end
    endtask

    // monitor: compares each write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_wr_en) begin
            exp_t e;
            writes_seen++;
            chk(done, "R2 done with write", {31'd0, done}, 32'd1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected write", {16'd0, mem_addr}, 32'd0);
            end else begin
                e = exp_q.pop_front();
                chk(mem_addr == e.a, "R3 write address", {16'd0, mem_addr}, {16'd0, e.a});
                chk(mem_wdata == e.w, "R3 write data", {28'd0, mem_wdata}, {28'd0, e.w});
            end
        end
    end

    task automatic send(input logic [12:0] w);
        instr_valid = 1'b1;
        instr_word  = w;
        model_exec(w);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic check_regs(input string req);
        chk(idx_x == mx, {req, " idx_x"}, {16'd0, idx_x}, {16'd0, mx});
        chk(idx_y == my, {req, " idx_y"}, {16'd0, idx_y}, {16'd0, my});
        chk(flag_z == mz, {req, " flag_z"}, {31'd0, flag_z}, {31'd0, mz});
        chk(flag_c == mc, {req, " flag_c"}, {31'd0, flag_c}, {31'd0, mc});
        chk(ext_pending == me, {req, " ext_pending"}, {31'd0, ext_pending}, {31'd0, me});
    endtask

    // one instruction, checking the read cycle (R2) and the result state
    task automatic run(input logic [12:0] w, input string req);
        send(w);
        chk(mem_rd_en && !mem_wr_en && !instr_ready, "R2 read cycle",
            {29'd0, mem_rd_en, mem_wr_en, instr_ready}, 32'd4);
        @(negedge clk);
        @(negedge clk);
        check_regs(req);
    endtask

    task automatic load_idx(input bit sel, input logic [15:0] v);
        idx_wr_en = 1'b1; idx_wr_sel = sel; idx_wr_data = v;
        @(negedge clk);
        idx_wr_en = 1'b0;
        if (sel) my = v; else mx = v;
    endtask

    task automatic load_flags(input bit c, input bit z);
        flag_wr_en = 1'b1; flag_wr_c = c; flag_wr_z = z;
        @(negedge clk);
        flag_wr_en = 1'b0;
        mc = c; mz = z;
    endtask

    task automatic give_prefix(input logic [7:0] v);
        prefix_valid = 1'b1; prefix_imm = v;
        @(negedge clk);
        prefix_valid = 1'b0;
        me = 1'b1; meimm = v;
    endtask

    bit finished = 0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int wbefore;
        logic [15:0] a;
        repeat (3) @(negedge clk);
        // R9 reset values
        chk(idx_x == 16'd0 && idx_y == 16'd0, "R9 index reset", {idx_x, idx_y}, 32'd0);
        chk(!flag_z && !flag_c && !ext_pending, "R9 flags reset", {29'd0, flag_z, flag_c, ext_pending}, 32'd0);
        chk(!mem_rd_en && !mem_wr_en && !done && instr_ready, "R9 strobes reset",
            {28'd0, mem_rd_en, mem_wr_en, done, instr_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 loads, R3 basic X form
        load_idx(1'b0, 16'h1234);
        load_idx(1'b1, 16'h00F0);
        check_regs("R10");
        run(13'h1B8A, "R3 X form");
        run(13'h1BA5, "R4 Y form");

        // R5 zero result with carry preserved
        load_flags(1'b1, 1'b0);
        a = mx;
        run(13'h1B80 | {9'd0, exp_rd(a)}, "R5 zero and carry");
        chk(flag_z == 1'b1, "R5 zero set", {31'd0, flag_z}, 32'd1);
        run(13'h1B87, "R5 nonzero");

        // R4 post-increment and wrap
        run(13'h1B93, "R4 post-inc X");
        load_idx(1'b1, 16'hFFFF);
        run(13'h1BB7, "R4 wrap Y");
        chk(idx_y == 16'h0000, "R4 wrap value", {16'd0, idx_y}, 32'd0);

        // R6 extended addressing
        give_prefix(8'h3C);
        chk(ext_pending, "R6 prefix pending", {31'd0, ext_pending}, 32'd1);
        run(13'h1B81, "R6 X page 00");
        give_prefix(8'hA7);
        run(13'h1BAE, "R6 Y page FF");

        // R7 post-inc ignores prefix but consumes it
        give_prefix(8'h55);
        run(13'h1B9C, "R7 post-inc with prefix");

        // R1 bad word ignored, prefix kept
        give_prefix(8'h12);
        wbefore = writes_seen;
        instr_valid = 1'b1; instr_word = 13'h1B4F;
        @(negedge clk);
        instr_valid = 1'b0;
        chk(!mem_rd_en, "R1 no read", {31'd0, mem_rd_en}, 32'd0);
        repeat (2) @(negedge clk);
        chk(writes_seen == wbefore, "R1 no write", writes_seen, wbefore);
        check_regs("R1");
        run(13'h1BA2, "R1 prefix still used");

        // R8 back-to-back with forwarding of the index update
        send(13'h1B91);
        @(negedge clk);
        send(13'h1B96);
        @(negedge clk);
        @(negedge clk);
        check_regs("R8 back-to-back");

        // R8 prefix and instruction together: prefix wins
        wbefore = writes_seen;
        prefix_valid = 1'b1; prefix_imm = 8'h40;
        instr_valid = 1'b1; instr_word = 13'h1B83;
        @(negedge clk);
        prefix_valid = 1'b0; instr_valid = 1'b0;
        me = 1'b1; meimm = 8'h40;
        repeat (2) @(negedge clk);
        chk(writes_seen == wbefore, "R8 dropped instruction", writes_seen, wbefore);
        check_regs("R8 prefix taken");
        run(13'h1B83, "R8 prefix then X");

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 32'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule